// File: doc/BRIEF.md
# Per-Line Input Delay Centering Calibrator

This block sets the sampling point of a bank of parallel single-data-rate input lines. Each line passes through an adjustable delay with 32 taps, and the taps together cover half of a data period. The input register samples the delayed line on both clock edges and presents both phases together on the rising edge. While the source sends an alternating one/zero training pattern, the calibrator takes the lines one at a time. It first forces every delay to tap 0. It then steps the active line through all taps with single increment strobes and records both phase samples at each tap. The phase-1 results go into entries 0..31 of a 64-entry map and the phase-2 results into entries 32..63, so the map covers one full data period.

After the sweep, the calibrator finds where the map changes value. It picks the position 32 entries (half a period) further on, modulo 64, and loads that tap into the line together with a phase choice. It then moves to the next line. A calibration runs by itself after every reset and again on each start request received while idle. A bypass input makes a run load fixed per-line taps instead of sweeping. The block drives a training-pattern request, which the converter's control logic turns into its alternating-pattern test mode. There is no data stream through the block, so every pin is a plain level or strobe and none carries valid/ready back-pressure.

Top module: `dly_cal_ctrl`

## Requirements
- R1: A calibration run starts by itself after reset is released, with no start request.
- R2: A start request while the block is idle begins a new run. A start request while a run is in progress is ignored: that run still ends in exactly one done pulse, and no further run follows.
- R3: The training-pattern request stays high from the first delay load until every line is programmed. It is low in the cycle where the done strobe is high, and that strobe lasts exactly one cycle.
- R4: At the start of a sweep, every line is loaded with tap 0. Each line then gets exactly 31 increment strobes. At most one line is stepped in any cycle, and an increment never coincides with a load.
- R5: Let E be the first map index i (1..63) where entry i differs from entry i-1. The programmed position is P = (E + 32) mod 64. P < 32 gives phase select 0 and tap P. P ≥ 32 gives phase select 1 and tap P − 32.
- R6: A map with exactly two transitions is accepted, and the first transition is used as E.
- R7: A map with no transition, or with more than two, sets that line's fail bit and raises the combined fail output. That line gets its bypass tap and phase select 0.
- R8: When bypass is high at the start of a run, every line is loaded with its bypass tap and phase select 0 and all fail bits clear. The training-pattern request stays low for the whole run.
- R9: Each map entry is the majority of 3 samples. The samples are taken only on alternate clock cycles, so a single corrupted sample in an entry's window does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start | input | 1 | Request a new run (accepted only when idle) |
| bypass_en | input | 1 | Load fixed taps instead of sweeping |
| byp_tap | input | 60 | Fixed tap per line, 5 bits per line, line 0 in the low bits |
| smp_ph1 | input | 12 | First-edge sample of each line |
| smp_ph2 | input | 12 | Second-edge sample of each line |
| dly_ld | output | 12 | Per-line strobe: load dly_val into the delay |
| dly_inc | output | 12 | Per-line strobe: advance the delay by one tap |
| dly_val | output | 60 | Per-line tap value for a load |
| phase_sel | output | 12 | Per-line phase choice, 0 = first edge, 1 = second edge |
| fail_map | output | 12 | Per-line calibration failure |
| cal_fail | output | 1 | Any line failed |
| pattern_req | output | 1 | Request the alternating training pattern |
| cal_busy | output | 1 | A run is in progress |
| cal_done | output | 1 | One-cycle end-of-run strobe |

## Verification
The bench models the delay lines and gives each line a transition at a chosen map position. The positions include the wrap points 1, 31, 32 and 63, where an off-by-one in the half-period offset or in the phase split would put a line on the wrong edge or at tap 31 instead of 0. Some lines carry a two-transition window, a flat map or a comb pattern. A design that counted transitions wrongly would either reject the window or center a failed line instead of falling back to its bypass tap. A second start request is sent in the middle of a run and noise is injected into single samples. These catch a design that restarts on every start, or one that votes over every cycle instead of alternate cycles, because both would corrupt the sampled map.

// File: rtl/dcal_pkg.sv
package dcal_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_BYP, S_ZERO, S_SETTLE, S_SAMPLE, S_STEP, S_SCAN, S_PROG, S_DONE
  } cal_st_e;
endpackage

// File: rtl/dcal_vote.sv
// Majority accumulator over VOTES qualifying samples.
module dcal_vote #(
  parameter int VOTES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic bit_in,
  output logic maj
);
  localparam int VW = $clog2(VOTES + 1);
  logic [VW-1:0] ones_q;
  logic [VW:0]   tot;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) ones_q <= '0;
    else if (en)       ones_q <= ones_q + VW'(bit_in);
  end

  // includes the sample arriving with the final vote
  always_comb begin
    tot = {1'b0, ones_q} + (VW + 1)'(bit_in);
    maj = (32'(tot) * 2) > VOTES;
  end
endmodule

// File: rtl/dcal_edge.sv
// Finds the first transition in a sample map and counts all transitions.
module dcal_edge #(
  parameter int N = 64
) (
  input  logic [N-1:0]         tbl,
  output logic                 ok,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);
  logic [IW:0] cnt;
  logic        found;

  always_comb begin
    cnt   = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = 1; i < N; i++) begin
      if (tbl[i] != tbl[i-1]) begin
        if (!found) begin
          idx   = IW'(i);
          found = 1'b1;
        end
        cnt = cnt + 1'b1;
      end
    end
    ok = (cnt != '0) && (cnt <= (IW + 1)'(2));
  end
endmodule

// File: rtl/dcal_lane.sv
// Per-line delay control registers: load/increment strobes, phase and fail.
module dcal_lane #(
  parameter int TAPW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_zero,
  input  logic            ld_byp,
  input  logic            ld_prog,
  input  logic            inc_req,
  input  logic            prog_ok,
  input  logic [TAPW-1:0] prog_tap,
  input  logic            prog_ph,
  input  logic [TAPW-1:0] byp_tap,
  output logic            dly_ld,
  output logic            dly_inc,
  output logic [TAPW-1:0] dly_val,
  output logic            phase_sel,
  output logic            fail
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly_ld    <= 1'b0;
      dly_inc   <= 1'b0;
      dly_val   <= '0;
      phase_sel <= 1'b0;
      fail      <= 1'b0;
    end else begin
      dly_ld  <= 1'b0;
      dly_inc <= inc_req;
      if (ld_zero) begin
        dly_ld    <= 1'b1;
        dly_val   <= '0;
        phase_sel <= 1'b0;
        fail      <= 1'b0;
      end else if (ld_byp) begin
        dly_ld    <= 1'b1;
        dly_val   <= byp_tap;
        phase_sel <= 1'b0;
        fail      <= 1'b0;
      end else if (ld_prog) begin
        dly_ld <= 1'b1;
        if (prog_ok) begin
          dly_val   <= prog_tap;
          phase_sel <= prog_ph;
          fail      <= 1'b0;
        end else begin
          dly_val   <= byp_tap;
          phase_sel <= 1'b0;
          fail      <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dly_cal_ctrl.sv
module dly_cal_ctrl
  import dcal_pkg::*;
#(
  parameter int NLINES = 12,
  parameter int TAPW   = 5,
  parameter int SETTLE = 4,
  parameter int VOTES  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cal_start,
  input  logic                   bypass_en,
  input  logic [NLINES*TAPW-1:0] byp_tap,
  input  logic [NLINES-1:0]      smp_ph1,
  input  logic [NLINES-1:0]      smp_ph2,
  output logic [NLINES-1:0]      dly_ld,
  output logic [NLINES-1:0]      dly_inc,
  output logic [NLINES*TAPW-1:0] dly_val,
  output logic [NLINES-1:0]      phase_sel,
  output logic [NLINES-1:0]      fail_map,
  output logic                   cal_fail,
  output logic                   pattern_req,
  output logic                   cal_busy,
  output logic                   cal_done
);
  localparam int NTAPS = 1 << TAPW;
  localparam int TBL   = 2 * NTAPS;
  localparam int LW    = (NLINES > 1) ? $clog2(NLINES) : 1;
  localparam int SW    = $clog2(SETTLE + 1);
  localparam int VW    = $clog2(VOTES + 1);

  cal_st_e          st_q;
  logic [LW-1:0]    line_q;
  logic [TAPW-1:0]  tap_q;
  logic [SW-1:0]    set_q;
  logic [VW-1:0]    vcnt_q;
  logic             ph_q;
  logic             auto_q;
  logic [TBL-1:0]   tbl_q;
  logic             res_ok_q;
  logic [TAPW:0]    res_pos_q;

  logic             s1, s2, m1, m2, vclr, vtake;
  logic             e_ok;
  logic [TAPW:0]    e_idx;

  assign s1    = smp_ph1[line_q];
  assign s2    = smp_ph2[line_q];
  assign vclr  = (st_q == S_SETTLE);
  assign vtake = (st_q == S_SAMPLE) && ph_q;

  dcal_vote #(.VOTES(VOTES)) u_vote1 (
    .clk(clk), .rst_n(rst_n), .clr(vclr), .en(vtake), .bit_in(s1), .maj(m1));
  dcal_vote #(.VOTES(VOTES)) u_vote2 (
    .clk(clk), .rst_n(rst_n), .clr(vclr), .en(vtake), .bit_in(s2), .maj(m2));

  dcal_edge #(.N(TBL)) u_edge (.tbl(tbl_q), .ok(e_ok), .idx(e_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      line_q    <= '0;
      tap_q     <= '0;
      set_q     <= '0;
      vcnt_q    <= '0;
      ph_q      <= 1'b0;
      auto_q    <= 1'b1;
      tbl_q     <= '0;
      res_ok_q  <= 1'b0;
      res_pos_q <= '0;
    end else begin
      ph_q <= ~ph_q;
      unique case (st_q)
        S_IDLE: if (auto_q || cal_start) begin
          auto_q <= 1'b0;
          st_q   <= bypass_en ? S_BYP : S_ZERO;
        end
        S_BYP: st_q <= S_DONE;
        S_ZERO: begin
          line_q <= '0;
          tap_q  <= '0;
          set_q  <= '0;
          st_q   <= S_SETTLE;
        end
        S_SETTLE: begin
          if (set_q == SW'(SETTLE - 1)) begin
            set_q  <= '0;
            vcnt_q <= '0;
            st_q   <= S_SAMPLE;
          end else begin
            set_q <= set_q + 1'b1;
          end
        end
        S_SAMPLE: if (ph_q) begin
          if (vcnt_q == VW'(VOTES - 1)) begin
            tbl_q[{1'b0, tap_q}] <= m1;
            tbl_q[{1'b1, tap_q}] <= m2;
            st_q <= (tap_q == TAPW'(NTAPS - 1)) ? S_SCAN : S_STEP;
          end else begin
            vcnt_q <= vcnt_q + 1'b1;
          end
        end
        S_STEP: begin
          tap_q <= tap_q + 1'b1;
          st_q  <= S_SETTLE;
        end
        S_SCAN: begin
          res_ok_q  <= e_ok;
          res_pos_q <= e_idx + (TAPW + 1)'(NTAPS);
          st_q      <= S_PROG;
        end
        S_PROG: begin
          if (line_q == LW'(NLINES - 1)) begin
            st_q <= S_DONE;
          end else begin
            line_q <= line_q + 1'b1;
            tap_q  <= '0;
            st_q   <= S_SETTLE;
          end
        end
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_lane
    dcal_lane #(.TAPW(TAPW)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_zero  (st_q == S_ZERO),
      .ld_byp   (st_q == S_BYP),
      .ld_prog  ((st_q == S_PROG) && (line_q == LW'(g))),
      .inc_req  ((st_q == S_STEP) && (line_q == LW'(g))),
      .prog_ok  (res_ok_q),
      .prog_tap (res_pos_q[TAPW-1:0]),
      .prog_ph  (res_pos_q[TAPW]),
      .byp_tap  (byp_tap[g*TAPW +: TAPW]),
      .dly_ld   (dly_ld[g]),
      .dly_inc  (dly_inc[g]),
      .dly_val  (dly_val[g*TAPW +: TAPW]),
      .phase_sel(phase_sel[g]),
      .fail     (fail_map[g])
    );
  end

  assign cal_fail    = |fail_map;
  assign cal_done    = (st_q == S_DONE);
  assign cal_busy    = (st_q != S_IDLE);
  assign pattern_req = (st_q == S_ZERO) || (st_q == S_SETTLE) || (st_q == S_SAMPLE) ||
                       (st_q == S_STEP) || (st_q == S_SCAN)   || (st_q == S_PROG);
endmodule

// File: rtl/dly_cal_ctrl_chk.sv
module dly_cal_ctrl_chk #(
  parameter int NLINES = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cal_busy,
  input logic              cal_done,
  input logic              pattern_req,
  input logic [NLINES-1:0] dly_ld,
  input logic [NLINES-1:0] dly_inc
);
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done);
  p_pat_low_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> !pattern_req);
  p_one_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dly_inc));
  p_inc_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|dly_inc) |-> !(|dly_ld));
  p_inc_in_train_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|dly_inc) |-> $past(pattern_req));
  p_run_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && !cal_done) |=> cal_busy);
endmodule

bind dly_cal_ctrl dly_cal_ctrl_chk #(.NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cal_busy(cal_busy), .cal_done(cal_done),
  .pattern_req(pattern_req), .dly_ld(dly_ld), .dly_inc(dly_inc));

// File: tb/dly_cal_ctrl_test.sv
module dly_cal_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 12;
  localparam int TW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_start = 1'b0;
  logic bypass_en = 1'b0;
  logic [NL*TW-1:0] byp_tap;
  logic [NL-1:0] smp_ph1, smp_ph2;
  logic [NL-1:0] dly_ld, dly_inc, phase_sel, fail_map;
  logic [NL*TW-1:0] dly_val;
  logic cal_fail, pattern_req, cal_busy, cal_done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // line models: 0 step at e1, 1 flat, 2 window [e1,e2), 3 comb
  int mode [NL];
  int e1 [NL];
  int e2 [NL];
  logic [NL-1:0] noise_en = '0;
  logic [TW-1:0] mtap [NL];
  int inc_cnt [NL];
  logic zero_first [NL];
  logic clr_stats = 1'b0;
  logic tog;

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_cal_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .bypass_en(bypass_en),
    .byp_tap(byp_tap), .smp_ph1(smp_ph1), .smp_ph2(smp_ph2),
    .dly_ld(dly_ld), .dly_inc(dly_inc), .dly_val(dly_val),
    .phase_sel(phase_sel), .fail_map(fail_map), .cal_fail(cal_fail),
    .pattern_req(pattern_req), .cal_busy(cal_busy), .cal_done(cal_done));

  function automatic int byp_of(int i);
    return (i * 3 + 7) % 32;
  endfunction

  function automatic logic fval(int i, int pos);
    case (mode[i])
      0: return logic'(pos >= e1[i]);
      1: return 1'b0;
      2: return logic'(pos >= e1[i] && pos < e2[i]);
      default: return logic'((pos >> 1) & 1);
    endcase
  endfunction

  always_comb begin
    for (int i = 0; i < NL; i++) byp_tap[i*TW +: TW] = TW'(byp_of(i));
  end

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      smp_ph1[i] = tog ^ fval(i, int'(mtap[i]))      ^ (noise_en[i] && (cyc % 6 == 1));
      smp_ph2[i] = tog ^ fval(i, int'(mtap[i]) + 32) ^ (noise_en[i] && (cyc % 6 == 1));
    end
  end

  // delay-line model and strobe statistics
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) tog <= 1'b0;
    else        tog <= ~tog;
    for (int i = 0; i < NL; i++) begin
      if (!rst_n) mtap[i] <= '0;
      else if (dly_ld[i]) mtap[i] <= dly_val[i*TW +: TW];
      else if (dly_inc[i] && mtap[i] != 5'd31) mtap[i] <= mtap[i] + 1'b1;
      if (clr_stats) begin
        inc_cnt[i]    <= 0;
        zero_first[i] <= 1'b0;
      end else begin
        if (dly_inc[i]) inc_cnt[i] <= inc_cnt[i] + 1;
        if (dly_ld[i] && dly_val[i*TW +: TW] == '0 && inc_cnt[i] == 0) zero_first[i] <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    @(negedge clk); clr_stats = 1'b1;
    @(negedge clk); clr_stats = 1'b0;
  endtask

  // waits for the done strobe; reports pattern_req behaviour during the run
  task automatic wait_done(input string req, output bit pat_gap, output bit pat_seen);
    int n;
    bit got;
    pat_gap = 0; pat_seen = 0; got = 0; n = 0;
    while (!got && n < 20000) begin
      @(negedge clk);
      n++;
      if (pattern_req) pat_seen = 1;
      if (cal_done) begin
        got = 1;
        chk(!pattern_req, "R3 pattern low at done", int'(pattern_req), 0);
      end else if (cal_busy && pat_seen && !pattern_req) pat_gap = 1;
    end
    chk(got, req, int'(got), 1);
    @(negedge clk);
    chk(!cal_done, "R3 done lasts one cycle", int'(cal_done), 0);
    @(negedge clk);
  endtask

  task automatic check_lines(input string tag);
    for (int i = 0; i < NL; i++) begin
      int et, ep, ef, pos;
      if (mode[i] == 1 || mode[i] == 3) begin
        et = byp_of(i); ep = 0; ef = 1;
      end else begin
        pos = (e1[i] + 32) % 64;
        ep = (pos >= 32) ? 1 : 0;
        et = pos % 32;
        ef = 0;
      end
      chk(int'(mtap[i]) == et, $sformatf("%s line %0d tap", tag, i), int'(mtap[i]), et);
      chk(int'(phase_sel[i]) == ep, $sformatf("%s line %0d phase", tag, i), int'(phase_sel[i]), ep);
      chk(int'(fail_map[i]) == ef, $sformatf("%s line %0d fail", tag, i), int'(fail_map[i]), ef);
    end
  endtask

  task automatic check_sweep();
    for (int i = 0; i < NL; i++) begin
      chk(zero_first[i] == 1'b1, $sformatf("R4 line %0d tap0 load first", i), int'(zero_first[i]), 1);
      chk(inc_cnt[i] == 31, $sformatf("R4 line %0d increments", i), inc_cnt[i], 31);
    end
  endtask

  task automatic t_reset_auto();
    bit gap, seen;
    int ed [NL] = '{1, 32, 31, 63, 5, 17, 40, 50, 2, 60, 25, 45};
    for (int i = 0; i < NL; i++) begin mode[i] = 0; e1[i] = ed[i]; e2[i] = 0; end
    noise_en = '0; bypass_en = 1'b0;
    rst_n = 1'b0; clr_stats = 1'b1;
    repeat (4) @(negedge clk);
    chk(!cal_done && !pattern_req && !cal_busy && !cal_fail, "R1 reset state",
        int'({cal_done, pattern_req, cal_busy, cal_fail}), 0);
    clr_stats = 1'b0;
    rst_n = 1'b1;
    wait_done("R1 automatic run completes", gap, seen);
    chk(seen && !gap, "R3 pattern held during run", int'(gap), 0);
    check_lines("R5 R1");
    check_sweep();
    chk(!cal_fail, "R5 no fail", int'(cal_fail), 0);
  endtask

  task automatic t_restart_mixed();
    bit gap, seen;
    bit again;
    for (int i = 0; i < NL; i++) begin mode[i] = 0; e1[i] = 8 + i * 4; end
    mode[0] = 2; e1[0] = 10; e2[0] = 40;
    mode[5] = 2; e1[5] = 33; e2[5] = 62;
    mode[3] = 1;
    mode[7] = 3;
    clear_stats();
    cal_start = 1'b1; @(negedge clk); cal_start = 1'b0;
    repeat (300) @(negedge clk);
    chk(cal_busy, "R2 run in progress", int'(cal_busy), 1);
    cal_start = 1'b1; @(negedge clk); cal_start = 1'b0;
    wait_done("R2 started run completes", gap, seen);
    chk(seen && !gap, "R3 pattern held during run", int'(gap), 0);
    check_lines("R6 R7");
    chk(cal_fail, "R7 combined fail", int'(cal_fail), 1);
    again = 0;
    repeat (100) begin @(negedge clk); if (cal_busy) again = 1; end
    chk(!again, "R2 start during run ignored", int'(again), 0);
  endtask

  task automatic t_bypass();
    bit gap, seen;
    for (int i = 0; i < NL; i++) begin mode[i] = 0; e1[i] = 20; end
    bypass_en = 1'b1;
    cal_start = 1'b1; @(negedge clk); cal_start = 1'b0;
    wait_done("R8 bypass run completes", gap, seen);
    chk(!seen, "R8 no pattern request", int'(seen), 0);
    for (int i = 0; i < NL; i++) begin
      chk(int'(mtap[i]) == byp_of(i), $sformatf("R8 line %0d tap", i), int'(mtap[i]), byp_of(i));
      chk(phase_sel[i] == 1'b0, $sformatf("R8 line %0d phase", i), int'(phase_sel[i]), 0);
    end
    chk(fail_map == '0, "R8 fails cleared", int'(fail_map), 0);
    bypass_en = 1'b0;
  endtask

  task automatic t_noise();
    bit gap, seen;
    int ed [NL] = '{3, 12, 30, 33, 44, 55, 62, 7, 19, 28, 36, 48};
    for (int i = 0; i < NL; i++) begin mode[i] = 0; e1[i] = ed[i]; end
    noise_en = '1;
    clear_stats();
    cal_start = 1'b1; @(negedge clk); cal_start = 1'b0;
    wait_done("R9 noisy run completes", gap, seen);
    check_lines("R9");
    check_sweep();
    noise_en = '0;
  endtask

  initial begin
    t_reset_auto();
    t_restart_mixed();
    t_bypass();
    t_noise();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule